// File: doc/BRIEF.md
# DSP Link Port Quad-Word Packer

This block sits between the receiver's output stage and a byte-wide link to a DSP. It can take I/Q words from four filter channels. It can also take I/Q words and gain (RSSI) words from two gain-control units, A and B. A configuration byte selects which of these words go into a fixed 16-byte quad-word and in what layout. On a data-ready pulse, the block snapshots the selected words and the configuration. It then waits a programmable start delay, which is never shorter than six cycles, and sends the quad-word one byte per accepted handshake, least-significant byte first.

The control FSM has three states. `ST_IDLE` waits for a request. `ST_WAIT` counts the start delay. `ST_SEND` puts bytes on the link.

The FSM has these transitions:
- *accept*: `ST_IDLE`→`ST_WAIT`, taken when the port is enabled and data-ready is seen.
- *expire*: `ST_WAIT`→`ST_SEND`, taken when the delay counter reaches zero.
- *hold/advance*: `ST_SEND`→`ST_SEND`, taken while bytes remain.
- *chain*: `ST_SEND`→`ST_WAIT`, taken when the last byte is accepted and a request is pending or arriving.
- *finish*: `ST_SEND`→`ST_IDLE`, taken when the last byte is accepted and no request is pending.
- *abort*: any state→`ST_IDLE`, taken when the enable bit is clear.

Top module: `lpk_link_packer`

## Requirements

The configuration byte `cfg_i` has these fields:
- bit 7: enable
- bits 6:3: programmed delay
- bit 2: omit gain words
- bit 1: wide/own select
- bit 0: source (0 = filter channels, 1 = gain units)

Slot k of a quad-word is bytes 4k..4k+3. A padded RSSI word is the 16-bit RSSI value followed by two zero bytes.

- R1: While `cfg_i[7]` is 0, `data_rdy_i` is ignored and `busy_o`/`lnk_vld_o` stay low. Clearing the bit mid-transfer returns the block to idle at the next edge and drops any pending request.
- R2: With `cfg_i[1:0]`=2'b10, slots 0..3 carry channel 0..3 I/Q, where channel k is `chan_iq_i[32k+31:32k]`.
- R3: With `cfg_i[1:0]`=2'b00, slots 0 and 1 carry channels 0 and 1, and bytes 8..15 are zero. Bit 2 has no effect in either filter mode.
- R4: With `cfg_i[1:0]`=2'b11, slot 0 carries unit A's I/Q and slot 1 carries unit A's padded RSSI (unit B with `AGC_SEL`=1). Bytes 8..15 are zero, and bit 2 has no effect.
- R5: With `cfg_i[2:0]`=3'b001, the slots carry, in order, A's I/Q, A's padded RSSI, B's I/Q and B's padded RSSI.
- R6: With `cfg_i[2:0]`=3'b101, slot 0 carries A's I/Q, slot 1 carries B's I/Q, and bytes 8..15 are zero.
- R7: Byte k of the quad-word is bits 8k+7:8k of the slot layout and is sent k-th. A byte advances only on an edge where `lnk_vld_o` and `lnk_rdy_i` are both high, and it is held stable otherwise.
- R8: The first byte is valid exactly D = max(6, `cfg_i[6:3]`) cycles after the edge that accepts the request.
- R9: `busy_o` rises at the accepting edge and stays high until the edge that takes byte 15. It is low in the following cycle unless a request is pending.
- R10: A `data_rdy_i` pulse seen while busy is held in a single-deep latch. The next quad-word's delay starts at the edge that takes the previous byte 15, and its source words and configuration are sampled at that edge.
- R11: After reset, `busy_o` and `lnk_vld_o` are low.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 8 | Enable, delay, gain-omit, mode and source fields |
| data_rdy_i | input | 1 | Data-ready request |
| chan_iq_i | input | 128 | Four 32-bit filter-channel I/Q words |
| agc_a_iq_i | input | 32 | Gain unit A I/Q word |
| agc_a_rssi_i | input | 16 | Gain unit A RSSI word |
| agc_b_iq_i | input | 32 | Gain unit B I/Q word |
| agc_b_rssi_i | input | 16 | Gain unit B RSSI word |
| lnk_rdy_i | input | 1 | DSP ready to take a byte |
| lnk_data_o | output | 8 | Current link byte |
| lnk_vld_o | output | 1 | Byte on `lnk_data_o` is valid |
| busy_o | output | 1 | Request accepted and quad-word not finished |

## Verification

- **Byte counter:** a wrong count shows as a short or long quad-word, or as bytes out of place. The error appears at the first byte that follows the fault and is visible through `busy_o` dropping early or late.
- **Delay counter:** a bad load or a missing clamp moves the first `lnk_vld_o` by one or more cycles, so a sweep over every programmed delay exposes it on the first byte of the affected quad-word.
- **Mode decode:** a wrong decode scrambles slots within the same quad-word.
- **Pending latch:** a lost or stuck pending bit shows as a missing or spurious second quad-word, visible one cycle after byte 15.

// File: rtl/lpk_pkg.sv
package lpk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } lpk_state_e;

    localparam int CFG_SRC     = 0;
    localparam int CFG_WIDE    = 1;
    localparam int CFG_NOGAIN  = 2;
    localparam int CFG_DLY_LSB = 3;
    localparam int CFG_EN      = 7;
    localparam int SLOTS       = 4;
endpackage

// File: rtl/lpk_quad_build.sv
module lpk_quad_build
    import lpk_pkg::*;
#(
    parameter int IQ_W    = 32,
    parameter int RS_W    = 16,
    parameter int AGC_SEL = 0
) (
    input  logic                    src_agc,
    input  logic                    wide,
    input  logic                    nogain,
    input  logic [SLOTS*IQ_W-1:0]   chan_iq,
    input  logic [IQ_W-1:0]         a_iq,
    input  logic [RS_W-1:0]         a_rssi,
    input  logic [IQ_W-1:0]         b_iq,
    input  logic [RS_W-1:0]         b_rssi,
    output logic [SLOTS*IQ_W-1:0]   quad
);
    localparam int PAD_W = IQ_W - RS_W;

    logic [IQ_W-1:0] rs_a_pad, rs_b_pad, own_iq, own_rs;
    logic [IQ_W-1:0] agc_slot [SLOTS];

    assign rs_a_pad = {{PAD_W{1'b0}}, a_rssi};
    assign rs_b_pad = {{PAD_W{1'b0}}, b_rssi};
    assign own_iq   = (AGC_SEL == 0) ? a_iq : b_iq;
    assign own_rs   = (AGC_SEL == 0) ? rs_a_pad : rs_b_pad;

    always_comb begin
        for (int s = 0; s < SLOTS; s++) agc_slot[s] = '0;
        if (wide) begin
            agc_slot[0] = own_iq;
            agc_slot[1] = own_rs;
        end else if (!nogain) begin
            agc_slot[0] = a_iq;
            agc_slot[1] = rs_a_pad;
            agc_slot[2] = b_iq;
            agc_slot[3] = rs_b_pad;
        end else begin
            agc_slot[0] = a_iq;
            agc_slot[1] = b_iq;
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [IQ_W-1:0] chan_word;
        if (s < 2) begin : g_base
            assign chan_word = chan_iq[s*IQ_W +: IQ_W];
        end else begin : g_ext
            assign chan_word = wide ? chan_iq[s*IQ_W +: IQ_W] : '0;
        end
        assign quad[s*IQ_W +: IQ_W] = src_agc ? agc_slot[s] : chan_word;
    end
endmodule

// File: rtl/lpk_start_timer.sv
module lpk_start_timer #(
    parameter int DLY_W   = 4,
    parameter int MIN_DLY = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] prog_i,
    input  logic             run_i,
    output logic             expired_o
);
    localparam int MW = $clog2(MIN_DLY + 1);
    localparam int TW = (MW > DLY_W) ? MW : DLY_W;

    logic [TW-1:0] cnt_q, eff;

    always_comb begin
        eff = TW'(prog_i);
        if (eff < TW'(MIN_DLY)) eff = TW'(MIN_DLY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (load_i)                    cnt_q <= eff - 1'b1;
        else if (run_i && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    // R8
    min_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q >= TW'(MIN_DLY - 1));
endmodule

// File: rtl/lpk_byte_ser.sv
module lpk_byte_ser #(
    parameter int BYTES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [8*BYTES-1:0] quad_i,
    input  logic               shift_i,
    output logic [7:0]         byte_o,
    output logic               last_o
);
    localparam int CW = $clog2(BYTES);

    logic [8*BYTES-1:0] sh_q;
    logic [CW-1:0]      idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            sh_q  <= quad_i;
            idx_q <= '0;
        end else if (shift_i) begin
            sh_q  <= sh_q >> 8;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign byte_o = sh_q[7:0];
    assign last_o = (idx_q == CW'(BYTES - 1));

    // R7
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> idx_q == CW'($past(idx_q) + 1'b1));
endmodule

// File: rtl/lpk_link_packer.sv
module lpk_link_packer
    import lpk_pkg::*;
#(
    parameter int IQ_W    = 32,
    parameter int RS_W    = 16,
    parameter int DLY_W   = 4,
    parameter int MIN_DLY = 6,
    parameter int AGC_SEL = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            cfg_i,
    input  logic                  data_rdy_i,
    input  logic [SLOTS*IQ_W-1:0] chan_iq_i,
    input  logic [IQ_W-1:0]       agc_a_iq_i,
    input  logic [RS_W-1:0]       agc_a_rssi_i,
    input  logic [IQ_W-1:0]       agc_b_iq_i,
    input  logic [RS_W-1:0]       agc_b_rssi_i,
    input  logic                  lnk_rdy_i,
    output logic [7:0]            lnk_data_o,
    output logic                  lnk_vld_o,
    output logic                  busy_o
);
    localparam int QBYTES = SLOTS * IQ_W / 8;

    lpk_state_e state_q, state_d;
    logic pend_q, pend_d;
    logic en, accept, take, last, expired;
    logic [SLOTS*IQ_W-1:0] quad;
    logic [7:0] ser_byte;

    assign en   = cfg_i[CFG_EN];
    assign take = (state_q == ST_SEND) && lnk_rdy_i;

    always_comb begin
        accept  = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (data_rdy_i) begin
                accept  = 1'b1;
                state_d = ST_WAIT;
            end
            ST_WAIT: if (expired) state_d = ST_SEND;
            ST_SEND: if (take && last) begin
                if (pend_q || data_rdy_i) begin
                    accept  = 1'b1;
                    state_d = ST_WAIT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (!en) begin
            accept  = 1'b0;
            state_d = ST_IDLE;
        end
        pend_d = en && !accept && (pend_q || (data_rdy_i && state_q != ST_IDLE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        lnk_vld_o  = (state_q == ST_SEND);
        busy_o     = (state_q != ST_IDLE);
        lnk_data_o = ser_byte;
    end

    lpk_quad_build #(.IQ_W(IQ_W), .RS_W(RS_W), .AGC_SEL(AGC_SEL)) u_build (
        .src_agc (cfg_i[CFG_SRC]),
        .wide    (cfg_i[CFG_WIDE]),
        .nogain  (cfg_i[CFG_NOGAIN]),
        .chan_iq (chan_iq_i),
        .a_iq    (agc_a_iq_i),
        .a_rssi  (agc_a_rssi_i),
        .b_iq    (agc_b_iq_i),
        .b_rssi  (agc_b_rssi_i),
        .quad    (quad)
    );

    lpk_start_timer #(.DLY_W(DLY_W), .MIN_DLY(MIN_DLY)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .prog_i    (cfg_i[CFG_DLY_LSB +: DLY_W]),
        .run_i     (state_q == ST_WAIT),
        .expired_o (expired)
    );

    lpk_byte_ser #(.BYTES(QBYTES)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .quad_i  (quad),
        .shift_i (take),
        .byte_o  (ser_byte),
        .last_o  (last)
    );

    // R1
    off_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy_o && !lnk_vld_o);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_vld_o && !lnk_rdy_i && en) |=> lnk_vld_o && $stable(lnk_data_o));

    // R9
    mid_quad_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_vld_o && lnk_rdy_i && !last && en) |=> lnk_vld_o && busy_o);
endmodule

// File: tb/lpk_link_packer_tb_top.sv
module lpk_link_packer_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [7:0]   cfg;
    logic         drdy, lrdy;
    logic [127:0] chan;
    logic [31:0]  a_iq, b_iq;
    logic [15:0]  a_rs, b_rs;
    logic [7:0]   ldata;
    logic         lvld, busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    lpk_link_packer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .data_rdy_i(drdy),
        .chan_iq_i(chan), .agc_a_iq_i(a_iq), .agc_a_rssi_i(a_rs),
        .agc_b_iq_i(b_iq), .agc_b_rssi_i(b_rs), .lnk_rdy_i(lrdy),
        .lnk_data_o(ldata), .lnk_vld_o(lvld), .busy_o(busy)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_cfg(input bit en, input int d, input bit nog, input bit wide, input bit src);
        return {en, 4'(d), nog, wide, src};
    endfunction

    function automatic logic [127:0] expect_quad(input logic [7:0] c);
        if (!c[0]) return c[1] ? chan : {64'h0, chan[63:0]};
        if (c[1])  return {80'h0, a_rs, a_iq};
        if (!c[2]) return {16'h0, b_rs, b_iq, 16'h0, a_rs, a_iq};
        return {64'h0, b_iq, a_iq};
    endfunction

    function automatic int eff_dly(input logic [7:0] c);
        return (int'(c[6:3]) < 6) ? 6 : int'(c[6:3]);
    endfunction

    task automatic randomize_src();
        chan = {$urandom, $urandom, $urandom, $urandom};
        a_iq = $urandom; b_iq = $urandom;
        a_rs = 16'($urandom); b_rs = 16'($urandom);
    endtask

    task automatic pulse_rdy();
        drdy = 1'b1;
        @(negedge clk);
        drdy = 1'b0;
    endtask

    task automatic measure(input int d, input string req);
        int n = 0;
        check(busy == 1'b1, "R9 busy at accept", 128'(busy), 128'd1);
        while (!lvld && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == d, req, 128'(n), 128'(d));
    endtask

    task automatic collect(input logic [127:0] exp, input bit stall, input int pulse_at,
                           input bit want_idle, input string req);
        logic [127:0] got = '0;
        int k = 0, cyc = 0;
        bit busy_ok = 1'b1;
        while (k < 16 && cyc < 200) begin
            bit r;
            r = !(stall && (cyc % 3 == 1));
            lrdy = r;
            drdy = (k == pulse_at);
            if (!busy || !lvld) busy_ok = 1'b0;
            if (lvld && r) begin
                got[8*k +: 8] = ldata;
                k++;
            end
            cyc++;
            @(negedge clk);
        end
        drdy = 1'b0;
        lrdy = 1'b1;
        check(got == exp, req, got, exp);
        check(busy_ok, "R9 busy/valid held during quad", 128'(busy_ok), 128'd1);
        if (want_idle)
            check(busy == 1'b0 && lvld == 1'b0, "R9 idle after byte 15", 128'(busy), 128'd0);
    endtask

    task automatic run_one(input logic [7:0] c, input bit stall, input string req);
        logic [127:0] e;
        cfg = c;
        randomize_src();
        e = expect_quad(c);
        pulse_rdy();
        randomize_src();
        measure(eff_dly(c), "R8 start delay");
        collect(e, stall, -1, 1'b1, req);
    endtask

    initial begin
        rst_n = 1'b0; cfg = '0; drdy = 1'b0; lrdy = 1'b1;
        chan = '0; a_iq = '0; b_iq = '0; a_rs = '0; b_rs = '0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && lvld == 1'b0, "R11 reset state", 128'({busy, lvld}), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && lvld == 1'b0, "R11 idle after release", 128'({busy, lvld}), 128'd0);

        for (int d = 0; d < 16; d++)
            run_one(mk_cfg(1, d, d[0], 1, 0), d[1], "R2 R7 four-channel layout");

        for (int nb = 0; nb < 2; nb++) begin
            run_one(mk_cfg(1, 7, 1'(nb), 0, 0), nb[0], "R3 two-channel layout");
            run_one(mk_cfg(1, 3, 1'(nb), 1, 1), nb[0], "R4 own-unit layout");
            run_one(mk_cfg(1, 9, 0, 0, 1), nb[0], "R5 alternating with gain");
            run_one(mk_cfg(1, 12, 1, 0, 1), nb[0], "R6 alternating without gain");
        end

        begin : pend_test
            logic [127:0] e1, e2;
            cfg = mk_cfg(1, 8, 0, 1, 0);
            randomize_src();
            e1 = expect_quad(cfg);
            pulse_rdy();
            randomize_src();
            e2 = expect_quad(cfg);
            measure(8, "R8 delay first of chained pair");
            collect(e1, 1'b1, 5, 1'b0, "R10 first quad of pair");
            check(busy == 1'b1 && lvld == 1'b0, "R10 chained delay starts", 128'({busy, lvld}), 128'b10);
            measure(8, "R10 chained start delay");
            collect(e2, 1'b0, -1, 1'b1, "R10 second quad sampled at service");
        end

        cfg = mk_cfg(0, 6, 0, 1, 0);
        pulse_rdy();
        begin : off_test
            bit quiet = 1'b1;
            repeat (12) begin
                if (busy || lvld) quiet = 1'b0;
                @(negedge clk);
            end
            check(quiet, "R1 request ignored while disabled", 128'(quiet), 128'd1);
        end

        cfg = mk_cfg(1, 6, 0, 1, 0);
        pulse_rdy();
        drdy = 1'b1;
        @(negedge clk);
        drdy = 1'b0;
        cfg[7] = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && lvld == 1'b0, "R1 abort on disable", 128'({busy, lvld}), 128'd0);
        cfg[7] = 1'b1;
        begin : drop_test
            bit quiet = 1'b1;
            repeat (12) begin
                if (busy || lvld) quiet = 1'b0;
                @(negedge clk);
            end
            check(quiet, "R1 pending dropped on disable", 128'(quiet), 128'd1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule